// File: doc/BRIEF.md
# I2C Target Interface with Stuck-Line Watchdog

This block is the bus-facing front end of a register-based peripheral. It watches the SCL and SDA pins of a two-wire bus through synchronisers and a short glitch filter. It recognises START and STOP, decodes a 7-bit target address followed by a direction bit, and moves data bytes between the bus and a register port. An internal byte pointer selects the register. The pins are open-drain, so the block never drives a line high: `scl_oe` and `sda_oe` mean "pull this line low".

On a write, the first data byte after the address sets the pointer. Every later byte becomes one request on the write channel at the current pointer, and the pointer then advances. On a read, each byte is fetched through a request on the read channel at the pointer, the pointer advances, and the byte is shifted out most significant bit first. While a request is pending, the block holds SCL low so that the host waits. A transaction must close with a STOP. A START that arrives in the middle of a transaction is not supported: the block drops the transfer and waits for the bus to go quiet. If either line stays low for `TIMEOUT_CYC` system clocks, an internal watchdog returns the interface to idle. With a 1 MHz clock, 12000 cycles gives about 12 ms.

Both register channels use valid/ready. A request (`wr_valid` or `rd_valid`) stays high with a stable address, and stable data on the write channel, until the cycle in which `*_ready` is sampled high. The transfer happens in that cycle. The requester never withdraws a request unless the watchdog fires. `rd_data` is taken in the cycle of the read handshake. `*_ready` may be held high permanently, or it may hold off the bus for any number of cycles.

Top module: `i2c_tgt_wd`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `wr_valid` and `rd_valid` are all low.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The first byte after START holds the address in bits 7..1, sent MSB first, and the direction in bit 0 (0 = write, 1 = read). When the address equals `tgt_addr`, the block pulls SDA low during the ninth clock.
- R3: A non-matching address is not acknowledged. Until the next START the block acknowledges nothing and raises no register request.
- R4: In a write, the first data byte loads the pointer and is acknowledged without a register request. Each later byte produces exactly one write request at the pointer, after which the pointer increments and wraps modulo 2^PTR_W. The two request channels are never active together.
- R5: Once the eighth bit of a write byte has been received, SCL is held low until the write handshake completes. The acknowledge is then given. Every SCL hold starts together with a pending request, and the request's address and data stay stable until accepted.
- R6: In a read, each byte is obtained by a read request at the pointer, with SCL held low until the handshake. The byte is sent MSB first and the pointer increments.
- R7: The block changes its SDA drive only while SCL is low.
- R8: A host NACK after a read byte ends the read. SDA is released and no further read request is made before the next START.
- R9: A START received while a transaction is open aborts it and is itself ignored. The following address byte gets no acknowledge. After a STOP, a new transaction works normally.
- R10: If SCL or SDA stays low for `TIMEOUT_CYC` consecutive cycles, the interface returns to idle. It releases SCL and SDA and drops any pending request.
- R11: A pulse on either line that lasts fewer than `FILT_LEN` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_addr | input | 7 | Configured target address |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Register side accepts the write |
| wr_addr | output | PTR_W | Write register address |
| wr_data | output | 8 | Write data |
| rd_valid | output | 1 | Read request pending |
| rd_ready | input | 1 | Register side supplies read data |
| rd_addr | output | PTR_W | Read register address |
| rd_data | input | 8 | Read data, taken at the handshake |

## Verification
The assertions assume that the host behaves like a well-formed bus master. It changes SDA only while SCL is low, except when it is creating START or STOP. It never holds a line low for a full timeout unless a stuck bus is intended. The SDA drive rule, and the rule that a request stays stable, are therefore tied to host behaviour that the bench guarantees.

The bench host keeps every phase at least ten system clocks long, well above the synchroniser and filter delay. It forces the low bit of every random byte to one, which keeps any continuous low run far below the timeout. The single glitch it injects is one clock wide, narrower than the filter.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_WAIT,
    ST_WR_ACK,
    ST_RD_FETCH,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
// Synchroniser followed by a persistence filter: the output follows the
// synchronised input only after it has differed for FILT_LEN clocks.
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (synced == line_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        line_o <= synced;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_stuck_wd.sv
// One low-time counter per bus line; a registered pulse when any reaches limit.
module i2c_stuck_wd #(
  parameter int unsigned TIMEOUT_CYC = 12000,
  parameter int          NLINES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_i,
  output logic              trip_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [NLINES-1:0] hit;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [CW-1:0] low_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   low_q <= '0;
      else if (line_i[g] || hit[g]) low_q <= '0;
      else                          low_q <= low_q + 1'b1;
    end
    assign hit[g] = !line_i[g] && (low_q == CW'(TIMEOUT_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_o <= 1'b0;
    else        trip_o <= |hit;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
// Bit/byte sequencer: framing, address match, ACK, stretch and register port.
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       tgt_addr,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             abort_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  tgt_state_e       state_q;
  logic             scl_prev, sda_prev;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_load_q, rw_q, host_ack_q;
  logic             scl_rise, scl_fall, start_ev, stop_ev, byte_done;

  assign scl_rise  = scl_f & ~scl_prev;
  assign scl_fall  = ~scl_f & scl_prev;
  assign start_ev  = scl_f & scl_prev & sda_prev & ~sda_f;
  assign stop_ev   = scl_f & scl_prev & ~sda_prev & sda_f;
  assign byte_done = scl_fall && (bit_cnt_q == 4'(BYTE_BITS));

  assign wr_addr = ptr_q;
  assign rd_addr = ptr_q;
  assign wr_data = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      scl_prev   <= 1'b1;
      sda_prev   <= 1'b1;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      ptr_load_q <= 1'b0;
      rw_q       <= 1'b0;
      host_ack_q <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      wr_valid   <= 1'b0;
      rd_valid   <= 1'b0;
    end else begin
      scl_prev <= scl_f;
      sda_prev <= sda_f;
      if (abort_i || stop_ev || (start_ev && state_q != ST_IDLE)) begin
        // stuck bus, end of transaction, or unsupported START mid-transfer
        state_q  <= ST_IDLE;
        scl_oe   <= 1'b0;
        sda_oe   <= 1'b0;
        wr_valid <= 1'b0;
        rd_valid <= 1'b0;
      end else if (start_ev) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              if (state_q == ST_ADDR) begin
                if (shreg_q[7:1] == tgt_addr) begin
                  rw_q    <= shreg_q[0];
                  sda_oe  <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (ptr_load_q) begin
                ptr_q      <= PTR_W'(shreg_q);
                ptr_load_q <= 1'b0;
                sda_oe     <= 1'b1;
                state_q    <= ST_WR_ACK;
              end else begin
                wr_valid <= 1'b1;
                scl_oe   <= 1'b1;
                state_q  <= ST_WR_WAIT;
              end
            end
          end
          ST_WR_WAIT: begin
            if (wr_ready) begin
              wr_valid <= 1'b0;
              ptr_q    <= ptr_q + 1'b1;
              sda_oe   <= 1'b1;
              state_q  <= ST_WR_ACK;
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            scl_oe <= 1'b0;  // ACK already on SDA; let the host clock it
            if (scl_fall) begin
              sda_oe    <= 1'b0;
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR_ACK && rw_q) begin
                rd_valid <= 1'b1;
                scl_oe   <= 1'b1;
                state_q  <= ST_RD_FETCH;
              end else begin
                if (state_q == ST_ADDR_ACK) ptr_load_q <= 1'b1;
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_RD_FETCH: begin
            if (rd_ready) begin
              rd_valid  <= 1'b0;
              shreg_q   <= rd_data;
              ptr_q     <= ptr_q + 1'b1;
              sda_oe    <= ~rd_data[7];
              bit_cnt_q <= '0;
              state_q   <= ST_RD_BYTE;
            end
          end
          ST_RD_BYTE: begin
            scl_oe <= 1'b0;
            if (scl_fall) begin
              if (bit_cnt_q == 4'(BYTE_BITS - 1)) begin
                sda_oe  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                sda_oe    <= ~shreg_q[6];
                shreg_q   <= {shreg_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_ack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (host_ack_q) begin
                rd_valid <= 1'b1;
                scl_oe   <= 1'b1;
                state_q  <= ST_RD_FETCH;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_wd.sv
module i2c_tgt_wd #(
  parameter int          PTR_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 12000,
  parameter int          FILT_LEN    = 3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       tgt_addr,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic              bus_stuck;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(clean_lines[g])
    );
  end

  i2c_stuck_wd #(.TIMEOUT_CYC(TIMEOUT_CYC), .NLINES(NLINES)) u_wd (
    .clk(clk), .rst_n(rst_n), .line_i(clean_lines), .trip_o(bus_stuck)
  );

  i2c_tgt_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tgt_addr(tgt_addr),
    .scl_f(clean_lines[0]), .sda_f(clean_lines[1]), .abort_i(bus_stuck),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2c_tgt_wd_chk.sv
module i2c_tgt_wd_chk #(
  parameter int          PTR_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 12000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [PTR_W-1:0] wr_addr,
  input logic [7:0]       wr_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PTR_W-1:0] rd_addr,
  input logic             bus_stuck
);
  logic [31:0] scl_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          scl_low_run <= '0;
    else if (scl_i)                      scl_low_run <= '0;
    else if (scl_low_run != 32'hFFFFFFFF) scl_low_run <= scl_low_run + 1'b1;
  end

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !bus_stuck) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !bus_stuck) |=> (rd_valid && $stable(rd_addr)));

  // R5
  stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (wr_valid || rd_valid));

  // R7
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R4
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  // R10
  stuck_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low_run > TIMEOUT_CYC + 16) |-> !scl_oe);
endmodule

bind i2c_tgt_wd i2c_tgt_wd_chk #(.PTR_W(PTR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .bus_stuck(bus_stuck)
);

// File: tb/test_i2c_tgt_wd.sv
module test_i2c_tgt_wd;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int TMO        = 1000;
  localparam logic [6:0] TGT = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl_low = 1'b0, h_sda_low = 1'b0;
  logic scl_oe, sda_oe, wr_valid, rd_valid;
  logic wr_ready = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_addr, wr_data, rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic scl_line, sda_line;

  assign scl_line = ~(h_scl_low | scl_oe);
  assign sda_line = ~(h_sda_low | sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_wd #(.PTR_W(8), .TIMEOUT_CYC(TMO), .FILT_LEN(3), .SYNC_STAGES(2)) i_i2c_tgt_wd (
    .clk(clk), .rst_n(rst_n), .tgt_addr(TGT), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] log_addr [256];
  logic [7:0] log_data [256];
  logic [7:0] payload [8];
  int log_n = 0, rd_fires = 0, r7_bad = 0, last_stretch = 0;
  bit stall_wr = 1'b0, saw_stretch = 1'b0, done = 1'b0;
  logic sda_oe_prev = 1'b0, scl_prev = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // register-side responder and monitors, all away from the active edge
  always @(negedge clk) begin
    wr_ready = stall_wr ? 1'b0 : ($urandom_range(0, 3) == 0);
    rd_ready = ($urandom_range(0, 3) == 0);
    rd_data  = mem[rd_addr];
    if (wr_valid && wr_ready) begin
      log_addr[log_n[7:0]] = wr_addr;
      log_data[log_n[7:0]] = wr_data;
      mem[wr_addr] = wr_data;
      log_n++;
    end
    if (rd_valid && rd_ready) rd_fires++;
    if (scl_oe) saw_stretch = 1'b1;
    if (rst_n && (sda_oe != sda_oe_prev) && scl_prev && scl_line) r7_bad++;
    sda_oe_prev = sda_oe;
    scl_prev    = scl_line;
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_scl();
    int cnt = 0;
    h_scl_low = 1'b0;
    @(negedge clk);
    while (scl_line !== 1'b1 && cnt < 5 * TMO) begin
      @(negedge clk);
      cnt++;
    end
    last_stretch = cnt;
  endtask

  task automatic bus_bit(input logic tx, input bit glitch, output logic rx);
    h_sda_low = ~tx;
    waitq(Q);
    if (glitch) begin
      h_scl_low = 1'b0;
      @(negedge clk);
      h_scl_low = 1'b1;
    end
    waitq(Q);
    release_scl();
    waitq(Q);
    rx = sda_line;
    waitq(Q);
    h_scl_low = 1'b1;
  endtask

  task automatic bus_start();
    h_sda_low = 1'b0;
    waitq(Q);
    release_scl();
    waitq(Q);
    h_sda_low = 1'b1;
    waitq(Q);
    h_scl_low = 1'b1;
    waitq(Q);
  endtask

  task automatic bus_stop();
    h_sda_low = 1'b1;
    waitq(Q);
    release_scl();
    waitq(Q);
    h_sda_low = 1'b0;
    waitq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit acked);
    logic rx;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], (i == glitch_bit), rx);
    bus_bit(1'b1, 1'b0, rx);
    acked = ~rx;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic rx;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 1'b0, rx);
      b[i] = rx;
    end
    bus_bit(~give_ack, 1'b0, rx);
  endtask

  task automatic do_write(input logic [7:0] ptr, input int n, input int glitch_bit);
    bit a;
    int base = log_n;
    bus_start();
    send_byte({TGT, 1'b0}, glitch_bit, a);
    check(a, "R2 address ACK (R11 when glitched)", int'(a), 1);
    send_byte(ptr, -1, a);
    check(a, "R4 pointer byte ACK", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(payload[i], -1, a);
      check(a, "R5 data byte ACK", int'(a), 1);
      ref_mem[8'(ptr + 8'(i))] = payload[i];
    end
    bus_stop();
    check(log_n == base + n, "R4 write request count", log_n - base, n);
    for (int i = 0; i < n; i++) begin
      check(log_addr[8'(base + i)] == 8'(ptr + 8'(i)), "R4 write address",
            int'(log_addr[8'(base + i)]), int'(8'(ptr + 8'(i))));
      check(log_data[8'(base + i)] == payload[i], "R4 write data",
            int'(log_data[8'(base + i)]), int'(payload[i]));
    end
  endtask

  task automatic do_read(input logic [7:0] ptr, input int n);
    bit a;
    logic [7:0] b;
    int fbase, wbase;
    wbase = log_n;
    bus_start();
    send_byte({TGT, 1'b0}, -1, a);
    send_byte(ptr, -1, a);
    bus_stop();
    check(log_n == wbase, "R4 pointer-only write makes no request", log_n - wbase, 0);
    fbase = rd_fires;
    bus_start();
    send_byte({TGT, 1'b1}, -1, a);
    check(a, "R2 read address ACK", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b == ref_mem[8'(ptr + 8'(i))], "R6 read data",
            int'(b), int'(ref_mem[8'(ptr + 8'(i))]));
    end
    waitq(2 * Q);
    check(!sda_oe && !rd_valid, "R8 released after host NACK",
          int'({sda_oe, rd_valid}), 0);
    bus_stop();
    check(rd_fires - fbase == n, "R8 read request count", rd_fires - fbase, n);
  endtask

  initial begin
    bit a;
    int base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom) | 8'h01;
      ref_mem[i] = mem[i];
    end
    waitq(5);
    rst_n = 1'b1;
    waitq(5);
    check(!scl_oe && !sda_oe && !wr_valid && !rd_valid, "R1 idle after reset",
          int'({scl_oe, sda_oe, wr_valid, rd_valid}), 0);

    // R3: foreign address
    base = log_n;
    bus_start();
    send_byte({TGT ^ 7'h01, 1'b0}, -1, a);
    check(!a, "R3 foreign address not acknowledged", int'(a), 0);
    send_byte(8'h35, -1, a);
    check(!a, "R3 byte after foreign address not acknowledged", int'(a), 0);
    bus_stop();
    check(log_n == base, "R3 no request after foreign address", log_n - base, 0);

    // random writes, then the pointer wrap corner
    for (int t = 0; t < 6; t++) begin
      int n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) payload[i] = 8'($urandom) | 8'h01;
      do_write(8'($urandom) | 8'h01, n, -1);
    end
    payload[0] = 8'hA5; payload[1] = 8'h3F; payload[2] = 8'h81;
    do_write(8'hFF, 3, -1);   // R4 wrap: 0xFF then 0x00, 0x01
    check(saw_stretch, "R5 SCL stretched while a write was pending", int'(saw_stretch), 1);

    // random reads, including across the wrap
    for (int t = 0; t < 5; t++) do_read(8'($urandom) | 8'h01, $urandom_range(1, 4));
    do_read(8'hFF, 3);

    // R11: one-clock SCL glitch inside the address byte
    payload[0] = 8'h77;
    do_write(8'h41, 1, 3);

    // R9: START before STOP
    base = log_n;
    bus_start();
    send_byte({TGT, 1'b0}, -1, a);
    send_byte(8'h11, -1, a);
    bus_start();
    send_byte({TGT, 1'b0}, -1, a);
    check(!a, "R9 address after mid-transfer START not acknowledged", int'(a), 0);
    send_byte(8'h5B, -1, a);
    check(!a, "R9 data after mid-transfer START not acknowledged", int'(a), 0);
    bus_stop();
    check(log_n == base, "R9 aborted transfer made no request", log_n - base, 0);
    payload[0] = 8'hC3;
    do_write(8'h20, 1, -1);

    // R10: register side never ready, watchdog must release the bus
    base = log_n;
    stall_wr = 1'b1;
    bus_start();
    send_byte({TGT, 1'b0}, -1, a);
    send_byte(8'h60, -1, a);
    send_byte(8'h99, -1, a);
    check(!a, "R10 no ACK once the watchdog reset the interface", int'(a), 0);
    check(last_stretch >= TMO - 3 * Q && last_stretch <= TMO + Q,
          "R10 stretch ended by the watchdog", last_stretch, TMO);
    check(!wr_valid && !scl_oe, "R10 request dropped and SCL released",
          int'({wr_valid, scl_oe}), 0);
    stall_wr = 1'b0;
    bus_stop();
    check(log_n == base, "R10 stalled write never accepted", log_n - base, 0);
    payload[0] = 8'h6D;
    do_write(8'h61, 1, -1);
    do_read(8'h5F, 3);

    check(r7_bad == 0, "R7 SDA drive changed only with SCL low", r7_bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule